// File: doc/BRIEF.md
# Interleaved Unit Index Scheduler

This block keeps the slot index of every unit in a pool of 2n−1 processing units that work on a stream of data chunks in a layered, interleaved fashion, with n = 2^D. Each unit holds a (D+1)-bit slot index in the range 1..2n−1. The number of trailing zeros of that index gives both the layer the unit computes and how many chunks back (the chunk age) the unit's chunk lies. Odd indices work on the newest chunk at layer 0. An index with one set bit followed by r zeros works on the chunk r steps old, at layer r.

On every cycle with the step strobe high, all slot indices are remapped at once. An index at or above n becomes 2(A−n)+1. These units fetch a fresh chunk. An index below n becomes 2A. These units keep their data and climb one layer. This rule is a one-bit left rotation of the index, so exactly n units reload on each step and the layer pattern is the same after every step. A fill counter tracks the first D steps after reset, while older chunk ages do not exist yet. Units whose age exceeds the number of steps taken are reported idle.

A consumer names a physical unit on the query input. The block returns that unit's current slot index and the index the unit will hold after the next step. It also returns the unit's chunk age, its layer, whether it must load new data at the next step, and whether it is active.

Top module: `unit_index_sched`

## Requirements
- R1: While reset is held and right after it, physical unit u (0 ≤ u ≤ 2n−2) holds slot index u+1, the fill count is zero and fillDone is low.
- R2: On each clock edge with stepStrobe high, every unit's slot index A becomes 2(A−n)+1 when A ≥ n and 2A when A < n. Consecutive strobe cycles each apply one remap. Without the strobe, no index changes.
- R3: chunkAge and layer both equal the number of trailing zero bits of the queried unit's slot index. Odd indices give 0, and the index n (only the top bit set) gives D.
- R4: loadNew equals bit D (the most significant bit) of the queried slot index, so loadNew is high exactly for indices ≥ n.
- R5: After any number of steps, the slot indices of all units form a permutation of 1..2n−1. Exactly n/2^r units have chunk age r, and exactly n units have loadNew high.
- R6: unitActive is high for a valid unit exactly when its chunk age is at most min(steps taken, D). After i < D steps, 2n − n/2^i units are active. Once filled, all 2n−1 units are active.
- R7: fillDone rises when D steps have been taken since reset and then stays high.
- R8: A queryUnit value of 2n−1 or above names no unit. For such a query, slotIdx, remapIdx, chunkAge and layer are 0, and loadNew and unitActive are low.
- R9: remapIdx is the index the queried unit will hold after the next step. After D+1 steps, every unit is back at its starting index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepStrobe | input | 1 | Advance all units by one time step |
| queryUnit | input | D+1 | Physical unit number to look up |
| slotIdx | output | D+1 | Current slot index of the queried unit |
| remapIdx | output | D+1 | Slot index after the next step |
| chunkAge | output | $clog2(D+1) | How many chunks back the unit works |
| layer | output | $clog2(D+1) | Layer the unit computes |
| loadNew | output | 1 | Unit fetches a new chunk at the next step |
| unitActive | output | 1 | Unit has work in the current step |
| fillDone | output | 1 | Initial fill of D steps complete |

## Verification
The checker watches, on every cycle, the per-unit properties visible at the query port. A step moves the queried unit to the index that remapIdx predicted, and without a step the index holds. Odd indices decode to age 0, and layer always matches age. The top age implies a reload, invalid queries read as zero and idle, all units are active once filled, and fillDone stays high. Only the bench scenarios can show the pool-wide properties: each step is a permutation with the right count per layer, the active count grows during the fill, the pool returns to its start after D+1 steps, and back-to-back strobes each apply one remap.

// File: rtl/unit_index_sched_pkg.sv
`timescale 1ns/1ps
package unit_index_sched_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;   // remap every slot this cycle
    logic filled;    // initial fill finished
  } schedCtrl_t;

  typedef enum logic {
    PH_FILL   = 1'b0,
    PH_STEADY = 1'b1
  } schedPhase_t;

endpackage

// File: rtl/unit_index_sched_ctrl.sv
`timescale 1ns/1ps
module unit_index_sched_ctrl
  import unit_index_sched_pkg::*;
#(
  parameter int D = 4,
  localparam int AGE_W = (D < 1) ? 1 : $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepStrobe,
  output schedCtrl_t       ctrl,
  output logic [AGE_W-1:0] fillLevel
);

  localparam logic [AGE_W-1:0] FILL_MAX = AGE_W'(D);

  schedPhase_t phase;
  logic [AGE_W-1:0] stepCount;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepCount <= '0;
      phase     <= PH_FILL;
    end else if (stepStrobe && phase == PH_FILL) begin
      stepCount <= stepCount + 1'b1;
      if (stepCount + 1'b1 == FILL_MAX) phase <= PH_STEADY;
    end
  end

  always_comb begin
    ctrl.advance = stepStrobe;
    ctrl.filled  = (phase == PH_STEADY);
    fillLevel    = stepCount;
  end

endmodule

// File: rtl/unit_index_decode.sv
`timescale 1ns/1ps
module unit_index_decode #(
  parameter int D = 4,
  localparam int IDX_W = D + 1,
  localparam int AGE_W = (D < 1) ? 1 : $clog2(D + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [AGE_W-1:0] age,
  output logic             topBit
);

  // Lowest set bit position gives chunk age and layer.
  always_comb begin
    logic found;
    found = 1'b0;
    age   = '0;
    for (int b = 0; b < IDX_W; b++) begin
      if (!found && idx[b]) begin
        age   = AGE_W'(b);
        found = 1'b1;
      end
    end
    topBit = idx[IDX_W-1];
  end

endmodule

// File: rtl/unit_index_sched_dp.sv
`timescale 1ns/1ps
module unit_index_sched_dp
  import unit_index_sched_pkg::*;
#(
  parameter int D = 4,
  localparam int IDX_W = D + 1,
  localparam int NUM_UNITS = (1 << (D + 1)) - 1,
  localparam int AGE_W = (D < 1) ? 1 : $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  schedCtrl_t       ctrl,
  input  logic [AGE_W-1:0] fillLevel,
  input  logic [IDX_W-1:0] queryUnit,
  output logic [IDX_W-1:0] slotIdx,
  output logic [IDX_W-1:0] remapIdx,
  output logic [AGE_W-1:0] chunkAge,
  output logic [AGE_W-1:0] layer,
  output logic             loadNew,
  output logic             unitActive
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_UNITS);

  logic [IDX_W-1:0] slotReg [NUM_UNITS];

  // One register per unit; the step is a one-bit left rotation.
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotReg[g] <= IDX_W'(g + 1);
      end else if (ctrl.advance) begin
        slotReg[g] <= {slotReg[g][IDX_W-2:0], slotReg[g][IDX_W-1]};
      end
    end
  end

  logic             queryValid;
  logic [IDX_W-1:0] picked;
  logic [AGE_W-1:0] decAge;
  logic             decTop;

  always_comb begin
    queryValid = (queryUnit < LIMIT);
    picked     = queryValid ? slotReg[queryUnit] : '0;
  end

  unit_index_decode #(.D(D)) u_decode (
    .idx   (picked),
    .age   (decAge),
    .topBit(decTop)
  );

  always_comb begin
    slotIdx    = picked;
    remapIdx   = {picked[IDX_W-2:0], picked[IDX_W-1]};
    chunkAge   = decAge;
    layer      = decAge;
    loadNew    = decTop;
    unitActive = queryValid && (ctrl.filled || decAge <= fillLevel);
  end

endmodule

// File: rtl/unit_index_sched.sv
`timescale 1ns/1ps
module unit_index_sched
  import unit_index_sched_pkg::*;
#(
  parameter int D = 4,
  localparam int IDX_W = D + 1,
  localparam int AGE_W = (D < 1) ? 1 : $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepStrobe,
  input  logic [IDX_W-1:0] queryUnit,
  output logic [IDX_W-1:0] slotIdx,
  output logic [IDX_W-1:0] remapIdx,
  output logic [AGE_W-1:0] chunkAge,
  output logic [AGE_W-1:0] layer,
  output logic             loadNew,
  output logic             unitActive,
  output logic             fillDone
);

  schedCtrl_t       ctrl;
  logic [AGE_W-1:0] fillLevel;

  unit_index_sched_ctrl #(.D(D)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .stepStrobe(stepStrobe),
    .ctrl      (ctrl),
    .fillLevel (fillLevel)
  );

  unit_index_sched_dp #(.D(D)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .fillLevel (fillLevel),
    .queryUnit (queryUnit),
    .slotIdx   (slotIdx),
    .remapIdx  (remapIdx),
    .chunkAge  (chunkAge),
    .layer     (layer),
    .loadNew   (loadNew),
    .unitActive(unitActive)
  );

  assign fillDone = ctrl.filled;

endmodule

// File: rtl/unit_index_sched_chk.sv
`timescale 1ns/1ps
module unit_index_sched_chk #(
  parameter int D = 4,
  localparam int IDX_W = D + 1,
  localparam int NUM_UNITS = (1 << (D + 1)) - 1,
  localparam int AGE_W = (D < 1) ? 1 : $clog2(D + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stepStrobe,
  input logic [IDX_W-1:0] queryUnit,
  input logic [IDX_W-1:0] slotIdx,
  input logic [IDX_W-1:0] remapIdx,
  input logic [AGE_W-1:0] chunkAge,
  input logic [AGE_W-1:0] layer,
  input logic             loadNew,
  input logic             unitActive,
  input logic             fillDone
);

  logic validQ;
  assign validQ = (32'(queryUnit) < NUM_UNITS);

  p_step_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stepStrobe) && $stable(queryUnit)) |-> (slotIdx == $past(remapIdx)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stepStrobe) && $stable(queryUnit)) |-> $stable(slotIdx));

  p_layer_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
    layer == chunkAge);

  p_odd_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slotIdx[0] |-> (chunkAge == '0));

  p_oldest_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (validQ && 32'(chunkAge) == D) |-> loadNew);

  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    validQ |-> (slotIdx != '0));

  p_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !validQ |-> (!unitActive && slotIdx == '0 && !loadNew));

  p_full_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fillDone && validQ) |-> unitActive);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fillDone |=> fillDone);

endmodule

bind unit_index_sched unit_index_sched_chk #(.D(D)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stepStrobe(stepStrobe),
  .queryUnit (queryUnit),
  .slotIdx   (slotIdx),
  .remapIdx  (remapIdx),
  .chunkAge  (chunkAge),
  .layer     (layer),
  .loadNew   (loadNew),
  .unitActive(unitActive),
  .fillDone  (fillDone)
);

// File: tb/unit_index_sched_tb.sv
`timescale 1ns/1ps
module unit_index_sched_tb;

  localparam int D = 4;
  localparam int N = 1 << D;
  localparam int NU = 2 * N - 1;
  localparam int IDX_W = D + 1;
  localparam int AGE_W = $clog2(D + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stepStrobe = 1'b0;
  logic [IDX_W-1:0] queryUnit = '0;
  logic [IDX_W-1:0] slotIdx, remapIdx;
  logic [AGE_W-1:0] chunkAge, layer;
  logic             loadNew, unitActive, fillDone;

  int total = 0;
  int bad = 0;
  int refIdx [NU];
  int stepsTaken = 0;

  always #2 clk = ~clk;

  unit_index_sched #(.D(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .stepStrobe(stepStrobe), .queryUnit(queryUnit),
    .slotIdx(slotIdx), .remapIdx(remapIdx), .chunkAge(chunkAge), .layer(layer),
    .loadNew(loadNew), .unitActive(unitActive), .fillDone(fillDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextIdx(input int a);
    return (a >= N) ? 2 * (a - N) + 1 : 2 * a;
  endfunction

  function automatic int tzCount(input int a);
    int c = 0;
    while (a > 0 && (a % 2) == 0) begin
      a = a / 2;
      c++;
    end
    return c;
  endfunction

  function automatic int minFill();
    return (stepsTaken < D) ? stepsTaken : D;
  endfunction

  // Advance k steps with the strobe held high k consecutive cycles.
  task automatic doSteps(input int k);
    @(negedge clk);
    stepStrobe = 1'b1;
    repeat (k) @(posedge clk);
    #1 stepStrobe = 1'b0;
    for (int s = 0; s < k; s++)
      for (int u = 0; u < NU; u++) refIdx[u] = nextIdx(refIdx[u]);
    stepsTaken += k;
    @(negedge clk);
  endtask

  // Query every unit and compare all per-unit outputs; also partition counts.
  task automatic scanAll(input string tag);
    int seen [NU + 1];
    int perAge [D + 1];
    int loads = 0;
    int active = 0;
    int errs = 0;
    int expActive = 0;
    for (int i = 0; i <= NU; i++) seen[i] = 0;
    for (int r = 0; r <= D; r++) perAge[r] = 0;
    for (int u = 0; u < NU; u++) begin
      int e;
      int ea;
      queryUnit = IDX_W'(u);
      #0.2;
      e  = refIdx[u];
      ea = tzCount(e);
      if (int'(slotIdx) != e) begin
        errs++; chk(0, {tag, " R2 slotIdx"}, int'(slotIdx), e);
      end
      if (int'(remapIdx) != nextIdx(e)) begin
        errs++; chk(0, {tag, " R9 remapIdx"}, int'(remapIdx), nextIdx(e));
      end
      if (int'(chunkAge) != ea || int'(layer) != ea) begin
        errs++; chk(0, {tag, " R3 age/layer"}, int'(chunkAge), ea);
      end
      if (loadNew != (e >= N)) begin
        errs++; chk(0, {tag, " R4 loadNew"}, int'(loadNew), int'(e >= N));
      end
      if (unitActive != (ea <= minFill())) begin
        errs++; chk(0, {tag, " R6 unitActive"}, int'(unitActive), int'(ea <= minFill()));
      end
      if (int'(slotIdx) >= 1 && int'(slotIdx) <= NU) seen[slotIdx]++;
      if (int'(chunkAge) <= D) perAge[chunkAge]++;
      loads += int'(loadNew);
      active += int'(unitActive);
    end
    chk(errs == 0, {tag, " R3 R4 per-unit decode"}, errs, 0);
    for (int i = 1; i <= NU; i++)
      if (seen[i] != 1) begin
        errs++; chk(0, {tag, " R5 permutation"}, seen[i], 1);
      end
    for (int r = 0; r <= D; r++)
      chk(perAge[r] == (N >> r), {tag, " R5 count per layer"}, perAge[r], N >> r);
    chk(loads == N, {tag, " R5 loaders"}, loads, N);
    for (int r = 0; r <= minFill(); r++) expActive += (N >> r);
    chk(active == expActive, {tag, " R6 active count"}, active, expActive);
    chk(fillDone == (stepsTaken >= D), {tag, " R7 fillDone"}, int'(fillDone), int'(stepsTaken >= D));
  endtask

  task automatic testReset();
    for (int u = 0; u < NU; u++) refIdx[u] = u + 1;
    stepsTaken = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.2;
    chk(fillDone == 1'b0, "R1 fillDone low after reset", int'(fillDone), 0);
    queryUnit = IDX_W'(NU - 1);
    #0.2;
    chk(int'(slotIdx) == NU, "R1 last unit index", int'(slotIdx), NU);
    scanAll("reset R1");
  endtask

  task automatic testFill();
    for (int i = 1; i <= D + 2; i++) begin
      doSteps(1);
      scanAll($sformatf("fill step %0d R6", i));
    end
  endtask

  task automatic testHold();
    @(negedge clk);
    repeat (6) @(negedge clk);
    scanAll("hold R2");
  endtask

  task automatic testBurst();
    doSteps(3);
    scanAll("burst R2");
    doSteps(2);
    scanAll("burst2 R2");
  endtask

  task automatic testPeriod();
    int rem;
    int errs = 0;
    rem = (D + 1) - (stepsTaken % (D + 1));
    if (rem != D + 1) doSteps(rem);
    for (int u = 0; u < NU; u++) begin
      queryUnit = IDX_W'(u);
      #0.2;
      if (int'(slotIdx) != u + 1) begin
        errs++; chk(0, "R9 period return", int'(slotIdx), u + 1);
      end
    end
    chk(errs == 0, "R9 all units home after multiple of D+1 steps", errs, 0);
    doSteps(D + 1);
    scanAll("period R9");
  endtask

  task automatic testInvalid();
    queryUnit = IDX_W'(NU);
    #0.2;
    chk(slotIdx == '0 && remapIdx == '0, "R8 invalid index zero", int'(slotIdx), 0);
    chk(chunkAge == '0 && layer == '0, "R8 invalid age zero", int'(chunkAge), 0);
    chk(!loadNew && !unitActive, "R8 invalid flags low", int'(unitActive), 0);
    doSteps(1);
    queryUnit = IDX_W'(NU);
    #0.2;
    chk(slotIdx == '0 && !unitActive, "R8 invalid after step", int'(slotIdx), 0);
  endtask

  task automatic testReReset();
    doSteps(2);
    testReset();
    doSteps(1);
    scanAll("rereset R6");
  endtask

  initial begin
    testReset();
    testFill();
    testHold();
    testBurst();
    testPeriod();
    testInvalid();
    testReReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule